// File: doc/BRIEF.md
# Serial Flash Sequential Read Responder

This block is the device side of a serial flash memory for the sequential read command. The serial pins (chip select, serial clock, serial data in) are taken in through synchronizers and sampled by a faster system clock. Edges of the serial clock are found by comparing synchronized samples. After chip select falls, the block gathers an 8-bit instruction and then a 24-bit address on serial clock rising edges. If the instruction is a read and no erase, program or write cycle is running, bytes are taken from an internal synchronous byte array and sent out most significant bit first on serial clock falling edges.

The read has no length limit. The address steps by one after every byte and wraps from the top of the array back to zero. Address bits above the array's own width are ignored. Raising chip select ends the transaction at once, even in the middle of a byte. A simple write port lets the surrounding environment load the array contents.

Top module: `sflash_read_responder`

## Requirements
- R1: After reset the output enable `sdo_oe` is 0.
- R2: A transaction is instruction byte 8'h03 followed by a 24-bit address. Both are sent MSB first and sampled on serial clock rising edges. The addressed byte is then sent MSB first, with each bit changing on a serial clock falling edge. The first bit is valid from the first falling edge after the last address bit.
- R3: Reading may start at any address. After each full byte the address steps up by one.
- R4: After the byte at address 2^MEM_AW-1, the next byte comes from address 0, and the read continues while clocks arrive.
- R5: Only address bits [MEM_AW-1:0] select the byte. Bits 23 down to MEM_AW are ignored.
- R6: `sdo_oe` is 0 during the instruction and address phases and whenever chip select is high.
- R7: A rise of chip select ends the read at any point, mid-byte included, and `sdo_oe` drops within 4 system clocks.
- R8: If `busy` is 1 when the eighth instruction bit is sampled, the read is rejected and `sdo_oe` stays 0 until chip select rises.
- R9: Any instruction code other than 8'h03 makes the block ignore the rest of the transaction, so `sdo_oe` stays 0.
- R10: An instruction or address cut short by chip select rising is dropped, and the next transaction decodes from scratch.
- R11: A transaction begins only on a falling edge of chip select. Chip select held low through the release of reset starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| sdi | input | 1 | Serial data input pin |
| busy | input | 1 | High while an erase, program or write cycle runs |
| load_en | input | 1 | Array write strobe |
| load_addr | input | MEM_AW | Array write address |
| load_data | input | 8 | Array write data |
| sdo | output | 1 | Serial data output, meaningful when `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable; 0 means the pin is high impedance |

## Verification
The hardest case to reach from the pins is the address wrap at the top of the array while the clock keeps running. It takes an unbroken stream that crosses address 2^MEM_AW-1. The bench gets there in two ways: it starts reads a few bytes below the top, and it also reads one pass longer than the whole array from address zero. Every byte is compared with an arithmetic pattern that was loaded beforehand. Mid-byte chip select release and a chip select already low at reset are handled by stopping or holding the serial stimulus at those exact points.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_SKIP = 3'd4
    } state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= pin_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sflash_read_responder.sv
module sflash_read_responder
    import sfr_pkg::*;
#(
    parameter int          MEM_AW      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  READ_OP     = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              busy,
    input  logic              load_en,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [7:0]        load_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CMD_BITS   = 8;
    localparam int ADDR_BITS  = 24;
    localparam int FRAME_BITS = CMD_BITS + ADDR_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int KEEP       = (MEM_AW > CMD_BITS) ? MEM_AW : CMD_BITS;

    typedef struct packed {
        state_e              st;
        logic                sck_p;
        logic                cs_p;
        logic [CNT_W-1:0]    cnt;
        logic [KEEP-2:0]     shin;
        logic [MEM_AW-1:0]   addr;
        logic [6:0]          shout;
        logic [2:0]          bitn;
        logic                sdo;
        logic                oe;
    } regs_t;

    regs_t q, d;

    logic       s_cs, s_sck, s_sdi;
    logic [7:0] rdata;

    // cs is synchronized as active-high "selected released" level (cs_n)
    pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({cs_n, sck, sdi}),
        .sync_o ({s_cs, s_sck, s_sdi})
    );

    byte_ram #(.AW(MEM_AW)) i_ram (
        .clk   (clk),
        .we    (load_en),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (q.addr),
        .rdata (rdata)
    );

    logic            rise, fall, sel_fall;
    logic [KEEP-1:0] shin_next;

    always_comb begin
        rise      = s_sck & ~q.sck_p;
        fall      = ~s_sck & q.sck_p;
        sel_fall  = ~s_cs & q.cs_p;
        shin_next = {q.shin, s_sdi};

        d       = q;
        d.sck_p = s_sck;
        d.cs_p  = s_cs;

        if (s_cs) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (sel_fall) begin
                        d.st  = ST_CMD;
                        d.cnt = '0;
                    end
                end
                ST_CMD: begin
                    if (rise) begin
                        d.shin = shin_next[KEEP-2:0];
                        d.cnt  = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(CMD_BITS - 1)) begin
                            d.st = (shin_next[7:0] == READ_OP && !busy) ? ST_ADDR : ST_SKIP;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rise) begin
                        d.shin = shin_next[KEEP-2:0];
                        d.cnt  = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                            d.st   = ST_DATA;
                            d.addr = shin_next[MEM_AW-1:0];
                            d.bitn = '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        d.oe   = 1'b1;
                        d.bitn = q.bitn + 3'd1;
                        if (q.bitn == 3'd0) begin
                            d.sdo   = rdata[7];
                            d.shout = rdata[6:0];
                            d.addr  = q.addr + 1'b1;
                        end else begin
                            d.sdo   = q.shout[6];
                            d.shout = {q.shout[5:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo    = q.oe & q.sdo;
    assign sdo_oe = q.oe;

    state_e            st_q;
    logic [MEM_AW-1:0] addr_q;
    assign st_q   = q.st;
    assign addr_q = q.addr;
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker
    import sfr_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              busy,
    input logic              sdo_oe,
    input state_e            st_q,
    input logic [MEM_AW-1:0] addr_q
);
    p_hiz_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

    p_drive_only_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> st_q == ST_DATA);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && $past(st_q) == ST_DATA && addr_q != $past(addr_q))
        |-> addr_q == MEM_AW'($past(addr_q) + 1'b1));

    p_busy_rejects_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR && $past(st_q) == ST_CMD) |-> !$past(busy));

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sdo_oe);
endmodule

bind sflash_read_responder sfr_checker #(.MEM_AW(MEM_AW)) i_sfr_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .busy   (busy),
    .sdo_oe (sdo_oe),
    .st_q   (st_q),
    .addr_q (addr_q)
);

// File: tb/test_sflash_read_responder.sv
module test_sflash_read_responder;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cs_n = 1'b0;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic          busy = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [7:0]    load_data = '0;
    logic          sdo, sdo_oe;

    int checks = 0;
    int errors = 0;

    sflash_read_responder #(.MEM_AW(AW)) i_sflash_read_responder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .busy(busy),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(((a % DEPTH) * 37 + 11) & 255);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic b, output logic so, output logic oe);
        sdi = b;
        tick(HALF);
        so = sdo;
        oe = sdo_oe;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, inout int oe_seen);
        logic so, oe;
        for (int i = n - 1; i >= 0; i--) begin
            bit_xfer(v[i], so, oe);
            oe_seen |= int'(oe);
        end
    endtask

    task automatic recv_byte(output logic [7:0] v, output int oe_all);
        logic so, oe;
        oe_all = 1;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b0, so, oe);
            v = {v[6:0], so};
            oe_all &= int'(oe);
        end
    endtask

    task automatic end_cmd();
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    // full read: opcode, 24-bit address, n bytes compared with pattern from exp_start
    task automatic read_run(string req, logic [7:0] op, logic [23:0] addr, int n,
                            int exp_start, bit expect_out);
        int oe_seen = 0;
        int oe_all;
        logic [7:0] v;
        cs_n = 1'b0;
        tick(HALF);
        send_bits({24'd0, op}, 8, oe_seen);
        send_bits({8'd0, addr}, 24, oe_seen);
        check({"R6 no drive in command/address ", req}, oe_seen, 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, oe_all);
            if (expect_out) begin
                check({req, " data byte"}, int'(v), int'(pat(exp_start + k)));
                check({req, " R6 drive during data"}, oe_all, 1);
            end else begin
                check({req, " output stays off"}, oe_all | int'(sdo_oe), 0);
            end
        end
        end_cmd();
        check("R6 off after deselect", int'(sdo_oe), 0);
    endtask

    initial begin
        int oe_seen;
        int oe_all;
        logic [7:0] v;

        // R11: chip select low through reset release
        cs_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check("R1 reset state oe", int'(sdo_oe), 0);

        for (int a = 0; a < DEPTH; a++) begin
            load_en = 1'b1; load_addr = AW'(a); load_data = pat(a);
            tick(1);
        end
        load_en = 1'b0;

        oe_seen = 0;
        send_bits(32'h0300_0010, 32, oe_seen);
        recv_byte(v, oe_all);
        check("R11 no start without select fall", oe_all | oe_seen | int'(sdo_oe), 0);
        end_cmd();

        // R2/R3: start-address sweep
        for (int s = 0; s < DEPTH; s += 5)
            read_run("R2 R3 sweep", 8'h03, 24'(s), 3, s, 1'b1);

        // R4: wrap near top, and a pass longer than the array
        read_run("R4 wrap near top", 8'h03, 24'(DEPTH - 6), 12, DEPTH - 6, 1'b1);
        read_run("R4 full pass", 8'h03, 24'h0, DEPTH + 4, 0, 1'b1);

        // R5: upper address bits ignored
        read_run("R5 upper bits", 8'h03, 24'hF12340, 2, 'h40, 1'b1);
        read_run("R5 upper bits", 8'h03, 24'h5A5AFF, 2, 'hFF, 1'b1);

        // R7: deselect mid-byte
        oe_seen = 0;
        cs_n = 1'b0; tick(HALF);
        send_bits({24'd0, 8'h03}, 8, oe_seen);
        send_bits(32'h10, 24, oe_seen);
        recv_byte(v, oe_all);
        check("R7 first byte before cut", int'(v), int'(pat('h10)));
        send_bits(32'h0, 3, oe_seen);
        cs_n = 1'b1;
        tick(4);
        check("R7 oe drops after mid-byte deselect", int'(sdo_oe), 0);
        tick(HALF);
        read_run("R7 fresh after cut", 8'h03, 24'h20, 2, 'h20, 1'b1);

        // R10: partial instruction, then partial address
        oe_seen = 0;
        cs_n = 1'b0; tick(HALF);
        send_bits(32'h0, 5, oe_seen);
        end_cmd();
        read_run("R10 after partial instruction", 8'h03, 24'h33, 2, 'h33, 1'b1);
        cs_n = 1'b0; tick(HALF);
        send_bits({24'd0, 8'h03}, 8, oe_seen);
        send_bits(32'hFFF, 12, oe_seen);
        end_cmd();
        check("R10 no drive on partial address", oe_seen, 0);
        read_run("R10 after partial address", 8'h03, 24'h44, 2, 'h44, 1'b1);

        // R8: busy rejects the read
        busy = 1'b1;
        read_run("R8 busy reject", 8'h03, 24'h00, 3, 0, 1'b0);
        busy = 1'b0;
        read_run("R8 after busy", 8'h03, 24'h07, 2, 7, 1'b1);

        // R9: other opcodes ignored
        read_run("R9 opcode 0B", 8'h0B, 24'h00, 3, 0, 1'b0);
        read_run("R9 opcode 83", 8'h83, 24'h00, 2, 0, 1'b0);
        read_run("R9 opcode 02", 8'h02, 24'h00, 2, 0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule